// File: doc/BRIEF.md
# Segmented converter input path

This block is the digital front end of an 8-bit voltage-output converter whose resistor ladder is split into two parts. The three most significant bits of the input word drive seven equally weighted segments through a thermometer code. The five least significant bits drive binary-weighted ladder taps. Before anything else, an optional complement stage inverts the whole word, so either polarity of source data can be used.

A single level-sensitive latch sits in front of all twelve driver lines. While the active-low enable is low the latch is transparent, and the drivers follow the conditioned input. Holding the enable low permanently gives unclocked operation. When the enable rises, the current word is captured and held for as long as the enable stays high. A reconstructed 8-bit code is also provided, so the driven ladder state can be compared against the input word. Only the logical code path and the latch timing are modelled. The analog parts are not.

Top module: `segdac_front`

## Requirements
- R1: When `cmpl_i` is 1, every bit of `data_i` is inverted before encoding. When it is 0, the word passes unchanged.
- R2: `seg_o[k-1]` (k = 1..7) is 1 exactly when bits 7:5 of the conditioned word, read as an unsigned value, are at least k. The pattern therefore fills from bit 0 upward with no gaps: 0 gives 7'b0000000 and 7 gives 7'b1111111.
- R3: A step of the conditioned word across any 1/8-scale boundary (32k-1 to 32k) toggles exactly one bit of `seg_o`.
- R4: While `le_ni` is 0, all outputs follow the current `data_i` and `cmpl_i`, including when the inputs change on every cycle.
- R5: On a rising edge of `le_ni` the conditioned word is captured. While `le_ni` stays 1, changes on `data_i` or `cmpl_i` leave all outputs unchanged.
- R6: `low_o` equals bits 4:0 of the same conditioned word that sets `seg_o`, because both pass through one shared latch.
- R7: `code_o` equals 32 times the number of 1 bits in `seg_o`, plus `low_o`. This value matches the conditioned word that is latched or being fed through.
- R8: While `rst_ni` is 0, all outputs are 0 (zero scale), whatever the state of `le_ni` and the data inputs. Reset acts at once, without any edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous active-low reset of the latch |
| data_i | input | 8 | Input word; bit 0 has weight 1, bit 7 has weight 128 |
| cmpl_i | input | 1 | Complement control; 1 inverts the word |
| le_ni | input | 1 | Latch enable, active low; low = transparent, rising edge captures |
| seg_o | output | 7 | Thermometer segment drive lines |
| low_o | output | 5 | Binary drive lines for the five low bits |
| code_o | output | 8 | Reconstructed code from the driven lines |

## Verification
A wrong latch state, such as a missed capture, a leak while the enable is high or a stale value after reset, shows at once on `seg_o`, `low_o` and `code_o`. These are pure functions of the latch contents, so the bench sees the error in the same half cycle as the enable or data change that exposes it. An encoder fault shows as a thermometer pattern with a gap or a wrong fill level, and so as a wrong `code_o` for some values of the upper bits. A complement fault appears as a mirrored code. The bench sweeps all 256 words with both complement settings, so every one of these faults is driven to the ports.

// File: rtl/segdac_pkg.sv
`timescale 1ns/1ps
package segdac_pkg;
  localparam int DATA_W_DEF = 8;
  localparam int TOP_W_DEF  = 3;

  function automatic int seg_lines(input int top_w);
    return (1 << top_w) - 1;
  endfunction
endpackage

// File: rtl/segdac_cond.sv
`timescale 1ns/1ps
module segdac_cond #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic         cmpl_i,
  output logic [W-1:0] cond_o
);
  always_comb begin
    for (int i = 0; i < W; i++) cond_o[i] = cmpl_i ? ~data_i[i] : data_i[i];
    // every bit flips, or none does
    assert_cond_xor_R1: assert ($countones(cond_o ^ data_i) == (cmpl_i ? W : 0));
  end
endmodule

// File: rtl/segdac_therm.sv
`timescale 1ns/1ps
module segdac_therm #(
  parameter int IN_W = 3
) (
  input  logic [IN_W-1:0]       up_i,
  output logic [(2**IN_W)-2:0]  therm_o
);
  localparam int OUT_W = (2**IN_W) - 1;

  always_comb begin
    for (int k = 1; k <= OUT_W; k++) therm_o[k-1] = (int'(up_i) >= k);
    assert_therm_level_R2: assert ($countones(therm_o) == int'(up_i));
  end
endmodule

// File: rtl/segdac_latch.sv
`timescale 1ns/1ps
module segdac_latch #(
  parameter int W = 12
) (
  input  logic         rst_ni,
  input  logic         le_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_latch begin
    if (!rst_ni)     q_o <= '0;
    else if (!le_ni) q_o <= d_i;
  end

  // check-only snapshot of the word present at each capture edge
  logic [W-1:0] snap_q;
  always_ff @(posedge le_ni or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else         snap_q <= d_i;
  end

  assert_hold_R5: assert property (@(negedge le_ni) disable iff (!rst_ni)
    q_o == snap_q);
endmodule

// File: rtl/segdac_recon.sv
`timescale 1ns/1ps
module segdac_recon #(
  parameter int TOP_W = 3,
  parameter int LOW_W = 5
) (
  input  logic [(2**TOP_W)-2:0]   seg_i,
  input  logic [LOW_W-1:0]        low_i,
  output logic [TOP_W+LOW_W-1:0]  code_o
);
  localparam int SEG_W = (2**TOP_W) - 1;

  logic [TOP_W-1:0] cnt;
  always_comb begin
    cnt = '0;
    for (int i = 0; i < SEG_W; i++) cnt = cnt + TOP_W'(seg_i[i]);
  end

  assign code_o = {cnt, low_i};
endmodule

// File: rtl/segdac_front.sv
`timescale 1ns/1ps
module segdac_front
  import segdac_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int TOP_W  = TOP_W_DEF
) (
  input  logic                       rst_ni,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       cmpl_i,
  input  logic                       le_ni,
  output logic [(2**TOP_W)-2:0]      seg_o,
  output logic [DATA_W-TOP_W-1:0]    low_o,
  output logic [DATA_W-1:0]          code_o
);
  localparam int LOW_W = DATA_W - TOP_W;
  localparam int SEG_W = seg_lines(TOP_W);
  localparam int LAT_W = SEG_W + LOW_W;

  logic [DATA_W-1:0] cond;
  logic [SEG_W-1:0]  therm;
  logic [LAT_W-1:0]  lat_q;

  segdac_cond #(.W(DATA_W)) u_cond (
    .data_i (data_i),
    .cmpl_i (cmpl_i),
    .cond_o (cond)
  );

  segdac_therm #(.IN_W(TOP_W)) u_therm (
    .up_i    (cond[DATA_W-1 -: TOP_W]),
    .therm_o (therm)
  );

  // one latch for all driver lines so they move together
  segdac_latch #(.W(LAT_W)) u_latch (
    .rst_ni (rst_ni),
    .le_ni  (le_ni),
    .d_i    ({therm, cond[LOW_W-1:0]}),
    .q_o    (lat_q)
  );

  assign seg_o = lat_q[LAT_W-1 -: SEG_W];
  assign low_o = lat_q[LOW_W-1:0];

  segdac_recon #(.TOP_W(TOP_W), .LOW_W(LOW_W)) u_recon (
    .seg_i  (seg_o),
    .low_i  (low_o),
    .code_o (code_o)
  );

  // just before capture the transparent outputs must carry the input word
  assert_capture_R7: assert property (@(posedge le_ni) disable iff (!rst_ni)
    code_o == cond);

  assert_no_gap_R2: assert property (@(posedge le_ni) disable iff (!rst_ni)
    ((seg_o + SEG_W'(1)) & seg_o) == SEG_W'(0));
endmodule

// File: tb/segdac_front_tb_top.sv
`timescale 1ns/1ps
module segdac_front_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] data;
  logic       cmpl;
  logic       le_n;
  logic [6:0] seg;
  logic [4:0] low;
  logic [7:0] code;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [7:0] ref_word;  // word the outputs must show

  always #10 clk = ~clk;  // 50 MHz

  segdac_front dut_i (
    .rst_ni (rst_n),
    .data_i (data),
    .cmpl_i (cmpl),
    .le_ni  (le_n),
    .seg_o  (seg),
    .low_o  (low),
    .code_o (code)
  );

  function automatic logic [7:0] cond_of(input logic [7:0] d, input logic c);
    return c ? (8'hFF - d) : d;
  endfunction

  function automatic logic [6:0] seg_of(input logic [7:0] w);
    int up;
    up = w / 32;
    return 7'((1 << up) - 1);
  endfunction

  task automatic chk(input string tag);
    n_chk += 3;
    if (seg !== seg_of(ref_word)) begin
      n_fail++;
      $display("FAIL %s/R2 seg act=%b exp=%b", tag, seg, seg_of(ref_word));
    end
    if (low !== ref_word[4:0]) begin
      n_fail++;
      $display("FAIL %s/R6 low act=%h exp=%h", tag, low, ref_word[4:0]);
    end
    if (code !== ref_word) begin
      n_fail++;
      $display("FAIL %s/R7 code act=%h exp=%h", tag, code, ref_word);
    end
  endtask

  task automatic vec(input logic [7:0] d, input logic c);
    @(posedge clk); data = d; cmpl = c;            // applied while held
    @(negedge clk); chk("R5 hold before release");
    @(posedge clk); le_n = 1'b0; ref_word = cond_of(d, c);
    @(negedge clk); chk(c ? "R1 transparent" : "R4 transparent");
    @(posedge clk); le_n = 1'b1;
    @(negedge clk); chk("R5 captured");
    @(posedge clk); data = ~d; cmpl = ~c;
    @(negedge clk); chk("R5 hold across data change");
  endtask

  initial begin
    rst_n = 1'b0; le_n = 1'b1; data = 8'h00; cmpl = 1'b0; ref_word = 8'h00;
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R8 reset state");
    // transparent with nonzero data while reset is held
    @(posedge clk); le_n = 1'b0; data = 8'hA7;
    @(negedge clk); chk("R8 reset over transparent");
    @(posedge clk); le_n = 1'b1;
    @(posedge clk); rst_n = 1'b1;
    @(negedge clk); chk("R8 after release");

    // full sweep, both complement settings
    for (int c = 0; c < 2; c++)
      for (int d = 0; d < 256; d++)
        vec(8'(d), c[0]);

    // 1/8-scale boundaries in feedthrough
    for (int c = 0; c < 2; c++) begin
      for (int k = 1; k < 8; k++) begin
        logic [6:0] prev;
        @(posedge clk); le_n = 1'b0; cmpl = c[0]; data = cond_of(8'(32*k - 1), c[0]);
        ref_word = 8'(32*k - 1);
        @(negedge clk); chk("R3 below boundary"); prev = seg;
        @(posedge clk); data = cond_of(8'(32*k), c[0]); ref_word = 8'(32*k);
        @(negedge clk); chk("R3 above boundary");
        n_chk++;
        if ($countones(prev ^ seg) != 1) begin
          n_fail++;
          $display("FAIL R3 toggled lines act=%0d exp=1", $countones(prev ^ seg));
        end
      end
    end

    // unclocked use: enable tied low, data every cycle
    cmpl = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); data = 8'((i * 37 + 11) % 256); ref_word = data;
      @(negedge clk); chk("R4 unclocked");
    end

    // async reset while holding a nonzero word
    @(posedge clk); le_n = 1'b1;
    @(negedge clk); chk("R5 captured before reset");
    @(posedge clk); rst_n = 1'b0; ref_word = 8'h00;
    @(negedge clk); chk("R8 async clear");
    @(posedge clk); rst_n = 1'b1; data = 8'hFF;
    @(negedge clk); chk("R8 hold after release");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule